// File: doc/BRIEF.md
# Debug Halting Control Register

This block is one word of debug control space for a small processor core. An external debugger reads and writes it over a plain 32-bit register bus. A write sets the four control lines that steer the core: halting debug enable, halt request, single step and interrupt masking. A read returns those lines together with a live snapshot of the core's debug status.

Writes are protected by a 16-bit key in the upper half of the write word. A write with any other key is dropped silently. Two event flags record that a core reset happened or that an instruction retired. They stay set until the debugger reads the register, and the read clears them. An event that lands in the same cycle as the clearing read is kept, so it shows up on the next read.

Read data is registered. It appears on `busRdData` in the cycle after the one in which `busRdEn` is sampled. While the register is not being read, `busRdData` is zero.

Top module: `halt_ctrl_reg`

## Requirements
- R1: A write to REG_ADDR updates the control bits only when busWrData[31:16] equals KEY (default 16'hA05F). Any other key leaves the control bits unchanged.
- R2: The control bits are written from busWrData bits 0 (debug enable), 1 (halt request), 2 (step enable) and 3 (interrupt mask), and read back at the same bit positions.
- R3: Read bit 25 is 1 when at least one coreRstEvt pulse has been seen since the previous read of REG_ADDR. That read clears the flag.
- R4: Read bit 24 is 1 when at least one coreRetire pulse has been seen since the previous read of REG_ADDR. That read clears the flag.
- R5: Read bits 19, 18, 17 and 16 return coreLockup, coreSleep, coreHalted and coreXferRdy as sampled at the reading edge.
- R6: An event that coincides with a clearing read is not shown by that read, but it keeps its flag set for the next read.
- R7: haltReq, stepEn and intMask carry their control bits only while debug enable is 1. Otherwise they are 0. dbgEn follows the debug enable bit.
- R8: Read bits 31..26, 23..20 and 15..4 are always zero.
- R9: After rstN is released, all control bits and both event flags are 0.
- R10: Accesses to any other address have no effect. A read there returns zero and clears no flag, and a keyed write there changes no control bit.
- R11: Read data appears one cycle after busRdEn is sampled. busRdData is zero in cycles that do not follow a read of REG_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Debug-domain reset, active low |
| busAddr | input | ADDR_W | Register bus address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data including key |
| busRdData | output | 32 | Registered read data |
| coreRstEvt | input | 1 | Core reset happened (pulse) |
| coreRetire | input | 1 | Instruction retired (pulse) |
| coreSleep | input | 1 | Core is sleeping |
| coreLockup | input | 1 | Core is in unrecoverable exception |
| coreHalted | input | 1 | Core is in debug state |
| coreXferRdy | input | 1 | Core register transfer complete |
| dbgEn | output | 1 | Halting debug enable |
| haltReq | output | 1 | Halt request (1) or resume request (0) |
| stepEn | output | 1 | Single-step enable |
| intMask | output | 1 | Mask configurable interrupts |

## Verification
The embedded properties check, on every cycle, the following:
- A control word changes only after an accepted write.
- The gated outputs are quiet whenever debug enable is low.
- Reserved read bits stay zero.
- A clearing read leaves a flag low unless an event arrived with it.
- The status field of a read matches the inputs one edge earlier.

Only the bench scenarios can show the full write-then-read round trip. These are the ones that depend on the whole sequence:
- The exact bit placement of each control bit.
- The survival of a coincident event through a read.
- The fact that reads at a foreign address leave the flags intact.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int DW       = 32;
  localparam int KEY_LSB  = 16;
  localparam int KEY_W    = DW - KEY_LSB;
  localparam int CTRL_W   = 4;
  // read-word bit positions (decoded by the debugger)
  localparam int XRDY_B   = 16;
  localparam int HLTD_B   = 17;
  localparam int SLP_B    = 18;
  localparam int LOCK_B   = 19;
  localparam int RET_B    = 24;
  localparam int RST_B    = 25;
  localparam int NUM_EVT  = 2;
  localparam int EVT_RET  = 0;
  localparam int EVT_RST  = 1;

  // [0]=enable [1]=halt [2]=step [3]=mask
  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrlBits_t;

  typedef struct packed {
    logic wr;
    logic rd;
  } hcrStrb_t;
endpackage

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
  import hcr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hDF0,
  parameter logic [KEY_W-1:0]  KEY      = 16'hA05F
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [KEY_W-1:0]  wrKey,
  output hcrStrb_t          strb
);
  logic hit;
  logic keyOk;

  assign hit    = (busAddr == REG_ADDR);
  assign keyOk  = (wrKey == KEY);
  assign strb.wr = busWrEn && hit && keyOk;
  assign strb.rd = busRdEn && hit;

  // R10: no strobe leaves this decoder for a foreign address
  a_r10_no_foreign: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != REG_ADDR) |-> (strb == '0));
endmodule

// File: rtl/hcr_dpath.sv
module hcr_dpath
  import hcr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hcrStrb_t          strb,
  input  logic [CTRL_W-1:0] wrCtrl,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic              coreSleep,
  input  logic              coreLockup,
  input  logic              coreHalted,
  input  logic              coreXferRdy,
  output ctrlBits_t         ctrlQ,
  output logic [DW-1:0]     rdData
);
  logic [NUM_EVT-1:0] stickyQ;
  logic [DW-1:0]      rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlQ <= '0;
    else if (strb.wr) ctrlQ <= ctrlBits_t'(wrCtrl);
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : gSticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stickyQ[g] <= 1'b0;
      else       stickyQ[g] <= (stickyQ[g] && !strb.rd) || evtIn[g];
    end
  end

  always_comb begin
    rdWord             = '0;
    rdWord[CTRL_W-1:0] = ctrlQ;
    rdWord[XRDY_B]     = coreXferRdy;
    rdWord[HLTD_B]     = coreHalted;
    rdWord[SLP_B]      = coreSleep;
    rdWord[LOCK_B]     = coreLockup;
    rdWord[RET_B]      = stickyQ[EVT_RET];
    rdWord[RST_B]      = stickyQ[EVT_RST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rd ? rdWord : '0;
  end

  // R1: control word moves only after an accepted write
  a_r1_hold_unkeyed: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wr |=> $stable(ctrlQ));
  // R3: clearing read with no new reset event drops the flag
  a_r3_rst_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && !evtIn[EVT_RST]) |=> !stickyQ[EVT_RST]);
  // R4: same for the retire flag
  a_r4_ret_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && !evtIn[EVT_RET]) |=> !stickyQ[EVT_RET]);
  // R6: an event is always recorded, read or not
  a_r6_evt_kept: assert property (@(posedge clk) disable iff (!rstN)
    evtIn[EVT_RET] |=> stickyQ[EVT_RET]);
  // R5: status field mirrors inputs at the reading edge
  a_r5_status: assert property (@(posedge clk) disable iff (!rstN)
    strb.rd |=> rdData[LOCK_B:XRDY_B] ==
      $past({coreLockup, coreSleep, coreHalted, coreXferRdy}));
  // R8: reserved bits read zero
  a_r8_rsvd: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[31:26] == '0) && (rdData[23:20] == '0) && (rdData[15:4] == '0));
endmodule

// File: rtl/halt_ctrl_reg.sv
module halt_ctrl_reg
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hDF0,
  parameter logic [15:0] KEY = 16'hA05F
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              coreRstEvt,
  input  logic              coreRetire,
  input  logic              coreSleep,
  input  logic              coreLockup,
  input  logic              coreHalted,
  input  logic              coreXferRdy,
  output logic              dbgEn,
  output logic              haltReq,
  output logic              stepEn,
  output logic              intMask
);
  hcrStrb_t  strb;
  ctrlBits_t ctrlQ;
  logic [NUM_EVT-1:0] evtIn;

  assign evtIn[EVT_RET] = coreRetire;
  assign evtIn[EVT_RST] = coreRstEvt;

  hcr_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .KEY(KEY)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .wrKey(busWrData[DW-1:KEY_LSB]), .strb(strb)
  );

  hcr_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrCtrl(busWrData[CTRL_W-1:0]),
    .evtIn(evtIn), .coreSleep(coreSleep), .coreLockup(coreLockup),
    .coreHalted(coreHalted), .coreXferRdy(coreXferRdy),
    .ctrlQ(ctrlQ), .rdData(busRdData)
  );

  assign dbgEn   = ctrlQ.en;
  assign haltReq = ctrlQ.en & ctrlQ.halt;
  assign stepEn  = ctrlQ.en & ctrlQ.step;
  assign intMask = ctrlQ.en & ctrlQ.mask;

  // R7: gated outputs stay low without debug enable
  a_r7_gated: assert property (@(posedge clk) disable iff (!rstN)
    !dbgEn |-> !(haltReq || stepEn || intMask));
endmodule

// File: tb/test_halt_ctrl_reg.sv
`timescale 1ns/1ps
module test_halt_ctrl_reg;
  localparam logic [11:0] RA  = 12'hDF0;
  localparam logic [15:0] KEY = 16'hA05F;

  logic clk = 0;
  logic rstN = 0;
  logic [11:0] busAddr = '0;
  logic busWrEn = 0, busRdEn = 0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic coreRstEvt = 0, coreRetire = 0, coreSleep = 0, coreLockup = 0;
  logic coreHalted = 0, coreXferRdy = 0;
  logic dbgEn, haltReq, stepEn, intMask;

  int compared = 0, mismatched = 0, cycles = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdPend = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  halt_ctrl_reg i_halt_ctrl_reg (.*);

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: read request, expected value goes into the scoreboard
  task automatic doRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRdEn = 1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 0;
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1; busWrData = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic pulse(input bit rst, input bit ret);
    @(negedge clk);
    coreRstEvt = rst; coreRetire = ret;
    @(negedge clk);
    coreRstEvt = 0; coreRetire = 0;
  endtask

  task automatic checkOuts(input logic [3:0] exp, input string tag);
    @(negedge clk);
    check({intMask, stepEn, haltReq, dbgEn} == exp, tag,
          {28'd0, intMask, stepEn, haltReq, dbgEn}, {28'd0, exp});
  endtask

  // monitor: one read result per pending read
  always @(posedge clk) rdPend <= busRdEn;
  always @(negedge clk) begin
    if (rdPend) begin
      if (expQ.size() == 0) check(0, "scoreboard underflow", busRdData, '0);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front(); t = tagQ.pop_front();
        check(busRdData == e, t, busRdData, e);
      end
    end else if (rstN) begin
      cycles++;
      if (busRdData !== 32'd0) check(0, "R11 idle read data", busRdData, '0);
    end
  end

  always @(posedge clk) begin
    if (!finished && cycles > 50000) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R9: reset state
    checkOuts(4'b0000, "R9 outputs after reset");
    doRead(RA, 32'h0, "R9 read after reset");
    // R1: wrong key ignored
    doWrite(RA, 32'hA05E_000F);
    doRead(RA, 32'h0, "R1 bad key ignored");
    checkOuts(4'b0000, "R1 outputs unchanged");
    // R7: bits set without enable stay off at outputs
    doWrite(RA, {KEY, 16'h000E});
    checkOuts(4'b0000, "R7 gated without enable");
    doRead(RA, 32'h0000_000E, "R2 readback without enable");
    // R2: full set
    doWrite(RA, {KEY, 16'h000F});
    checkOuts(4'b1111, "R7 outputs with enable");
    doRead(RA, 32'h0000_000F, "R2 readback all");
    doWrite(RA, {KEY, 16'h0005});
    checkOuts(4'b0101, "R2 step plus enable");
    doRead(RA, 32'h0000_0005, "R2 readback step");
    // R10: foreign address
    doWrite(12'hDF4, {KEY, 16'h0000});
    doRead(RA, 32'h0000_0005, "R10 foreign write ignored");
    // R5: status inputs
    coreLockup = 1; coreHalted = 1;
    doRead(RA, 32'h000A_0005, "R5 lockup+halted");
    coreLockup = 0; coreHalted = 0; coreSleep = 1; coreXferRdy = 1;
    doRead(RA, 32'h0005_0005, "R5 sleep+xfer");
    coreSleep = 0; coreXferRdy = 0;
    // R3 / R4: sticky flags
    pulse(1, 0);
    pulse(0, 1);
    pulse(0, 1);
    doRead(12'hDF8, 32'h0, "R10 foreign read returns zero");
    doRead(RA, 32'h0300_0005, "R3 R4 sticky set");
    doRead(RA, 32'h0000_0005, "R3 R4 cleared by read");
    // R6: event coincident with read
    pulse(0, 1);
    @(negedge clk);
    busAddr = RA; busRdEn = 1; coreRetire = 1; coreRstEvt = 1;
    expQ.push_back(32'h0100_0005); tagQ.push_back("R6 coincident read");
    @(negedge clk);
    busRdEn = 0; coreRetire = 0; coreRstEvt = 0;
    doRead(RA, 32'h0300_0005, "R6 coincident event kept");
    doRead(RA, 32'h0000_0005, "R6 then cleared");
    // R1: key checked again, halt resume
    doWrite(RA, {16'h5FA0, 16'h0000});
    checkOuts(4'b0101, "R1 swapped key ignored");
    doWrite(RA, {KEY, 16'h0000});
    checkOuts(4'b0000, "R2 clear all");
    // R8: reserved bits stay zero even if written
    doWrite(RA, {KEY, 16'hFFF3});
    doRead(RA, 32'h0000_0003, "R8 reserved zero");
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule